// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers interrupt requests from a wide set of level-sensitive hardware lines and a handful of software-settable request bits. Each request source carries its own 4-bit priority, set through a small register port. On every cycle the block picks the pending source with the highest priority. Ties go to the lowest source number. If that priority beats the processor's current priority, the block raises a single interrupt line and presents the source number as the vector.

The processor accepts the presented vector with a one-cycle acknowledge strobe. The block then saves the current priority on an internal LIFO and adopts the priority of the accepted source, so that only strictly more urgent requests can preempt the running handler. A one-cycle end-of-interrupt strobe restores the saved priority. Handlers can therefore nest up to the depth of the LIFO.

The interrupt line and the acknowledge strobe form the only handshake. While the line is high, the vector may still change to a more urgent source. The acknowledge takes whatever vector is presented in its cycle, and an acknowledge with the line low is dropped. Configuration accesses are single-cycle, with no wait states.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Sources 0 to 7 are software sources. Source i from 8 to 154 is the hardware line `hw_req[i-8]`, which is level-sensitive: it is pending exactly while it is high.
- R2: Writing address i (below 155) stores `cfg_wdata[3:0]` as the priority of source i, and reading that address returns it in `cfg_rdata[3:0]`. A source whose priority is 0 never raises the interrupt.
- R3: `irq_o` is high only when the highest priority among pending sources is strictly greater than `cur_prio`. In that case `irq_vec` carries the winning source number; otherwise `irq_vec` is 0.
- R4: Among pending sources sharing the highest priority, the lowest-numbered source wins.
- R5: An acknowledge taken while `irq_o` is high pushes `cur_prio` onto a 16-entry LIFO and loads the presented winner's priority into `cur_prio`.
- R6: An end-of-interrupt pops the most recently saved priority back into `cur_prio`.
- R7: `stack_err` is set, and then stays set until reset, in two cases: an end-of-interrupt arrives with the LIFO empty, in which case `cur_prio` is left unchanged; or an acknowledge arrives with the LIFO full, in which case nothing is stored but `cur_prio` is still raised.
- R8: Address 256 controls the software sources. A write sets the pending bits given in `cfg_wdata[7:0]` and clears those given in `cfg_wdata[15:8]`, and a clear wins over a set of the same bit. A read returns the pending bits in `cfg_rdata[7:0]`. These bits are never changed by acknowledge or end-of-interrupt.
- R9: Address 257 reads and writes `cur_prio` through bits [3:0]. Address 258 reads `stack_err` in bit 0 and the LIFO depth in bits [5:1].
- R10: `irq_o` and `irq_vec` are registered. A change on `hw_req` shows one rising edge later, and a priority or software-bit write shows two edges later.
- R11: An acknowledge while `irq_o` is low has no effect. When acknowledge and end-of-interrupt arrive in the same cycle, the end-of-interrupt is ignored. Acknowledge, end-of-interrupt and a write to address 257 take precedence in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, combinational from `cfg_addr` |
| hw_req | input | 147 | Hardware request lines for sources 8 to 154 |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec | output | 9 | Presented source number |
| irq_ack | input | 1 | Acknowledge strobe |
| irq_eoi | input | 1 | End-of-interrupt strobe |
| cur_prio | output | 4 | Current priority |
| stack_err | output | 1 | Sticky LIFO underflow or overflow flag |

## Verification
Each result has a known latency:
- `hw_req` changes reach `irq_o` and `irq_vec` after one rising edge.
- Priority and software-bit writes reach them after two edges.
- Acknowledge, end-of-interrupt and current-priority writes update `cur_prio`, `stack_err` and `irq_o` together after one edge.
- `cfg_rdata` follows `cfg_addr` within the same cycle.

The bench drives inputs at the falling edge and lets two rising edges pass after every operation. It then compares all outputs with its own model at the falling edge. Two directed cases probe the exact single-edge and two-edge latencies by sampling between the edges.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_PRIO_W = 4;
  localparam int unsigned PIC_VEC_W  = 9;

  typedef enum logic [2:0] {
    REG_PRIO,
    REG_SWP,
    REG_CUR,
    REG_STAT,
    REG_NONE
  } reg_sel_e;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 155,
  parameter int unsigned NUM_SW  = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DEPTH_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SW-1:0]         sw_pend,
  output logic                      cur_we,
  output logic [PRIO_W-1:0]         cur_wval,
  input  logic [PRIO_W-1:0]         cur_prio,
  input  logic [DEPTH_W-1:0]        stk_depth,
  input  logic                      stk_err
);
  localparam logic [ADDR_W-1:0] SWP_ADDR  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] CUR_ADDR  = SWP_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = SWP_ADDR + ADDR_W'(2);

  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  reg_sel_e          sel;
  logic              sw_we;
  logic [NUM_SW-1:0] sw_set, sw_clr;
  logic [PRIO_W-1:0] prio_rd;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    if (cfg_addr < ADDR_W'(NUM_SRC)) sel = REG_PRIO;
    else if (cfg_addr == SWP_ADDR)   sel = REG_SWP;
    else if (cfg_addr == CUR_ADDR)   sel = REG_CUR;
    else if (cfg_addr == STAT_ADDR)  sel = REG_STAT;
    else                             sel = REG_NONE;
  end

  // per-source priority table
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rst_n)
        prio_q[i] <= '0;
      else if (cfg_we && sel == REG_PRIO && cfg_addr == ADDR_W'(i))
        prio_q[i] <= cfg_wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  // software request bits: clear beats set
  assign sw_we  = cfg_we && sel == REG_SWP;
  assign sw_set = cfg_wdata[NUM_SW-1:0];
  assign sw_clr = cfg_wdata[2*NUM_SW-1:NUM_SW];

  always_ff @(posedge clk) begin
    if (!rst_n)     sw_pend <= '0;
    else if (sw_we) sw_pend <= (sw_pend | sw_set) & ~sw_clr;
  end

  assign cur_we   = cfg_we && sel == REG_CUR;
  assign cur_wval = cfg_wdata[PRIO_W-1:0];

  always_comb begin
    prio_rd = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (cfg_addr == ADDR_W'(i)) prio_rd = prio_q[i];
  end

  always_comb begin
    case (sel)
      REG_PRIO: cfg_rdata = DATA_W'(prio_rd);
      REG_SWP:  cfg_rdata = DATA_W'(sw_pend);
      REG_CUR:  cfg_rdata = DATA_W'(cur_prio);
      REG_STAT: cfg_rdata = DATA_W'({stk_depth, stk_err});
      default:  cfg_rdata = '0;
    endcase
  end

  // R8: software bits change only on a write to their register
  a_r8_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> $stable(sw_pend));
  // R8: a bit named for clearing is low after the write
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (sw_pend & $past(sw_clr)) == '0);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_SRC = 155,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned VEC_W   = 9
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [VEC_W-1:0]          win_id,
  output logic [PRIO_W-1:0]         win_prio
);
  // Ascending scan with a strict compare: an equal priority found later
  // never displaces an earlier source, and priority 0 never wins.
  always_comb begin
    win_id   = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && prio_flat[i*PRIO_W +: PRIO_W] > win_prio) begin
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
        win_id   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DEPTH_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_take,
  input  logic               eoi_req,
  input  logic [PRIO_W-1:0]  ack_prio,
  input  logic               cur_we,
  input  logic [PRIO_W-1:0]  cur_wval,
  output logic [PRIO_W-1:0]  cur_q,
  output logic [PRIO_W-1:0]  cur_next,
  output logic [DEPTH_W-1:0] depth_q,
  output logic               err_q
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [PRIO_W-1:0] mem [DEPTH];
  logic              full, empty;
  logic [IDX_W-1:0]  push_idx, top_idx;

  assign full     = depth_q == DEPTH_W'(DEPTH);
  assign empty    = depth_q == '0;
  assign push_idx = depth_q[IDX_W-1:0];
  assign top_idx  = depth_q[IDX_W-1:0] - IDX_W'(1);

  // acknowledge beats end-of-interrupt, which beats a register write
  always_comb begin
    if (ack_take)     cur_next = ack_prio;
    else if (eoi_req) cur_next = empty ? cur_q : mem[top_idx];
    else if (cur_we)  cur_next = cur_wval;
    else              cur_next = cur_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      cur_q <= cur_next;
      if (ack_take) begin
        if (full) err_q <= 1'b1;
        else      depth_q <= depth_q + DEPTH_W'(1);
      end else if (eoi_req) begin
        if (empty) err_q <= 1'b1;
        else       depth_q <= depth_q - DEPTH_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ack_take && !full) mem[push_idx] <= cur_q;
  end

  a_r5_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take && !full |=> depth_q == $past(depth_q) + DEPTH_W'(1));
  a_r6_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req && !ack_take && !empty |=> depth_q == $past(depth_q) - DEPTH_W'(1));
  a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req && !ack_take && empty |=> err_q && cur_q == $past(cur_q));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(DEPTH));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 155,
  parameter int unsigned NUM_SW      = 8,
  parameter int unsigned PRIO_W      = PIC_PRIO_W,
  parameter int unsigned VEC_W       = PIC_VEC_W,
  parameter int unsigned STACK_DEPTH = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = $clog2(NUM_SRC) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  input  logic [NUM_SRC-NUM_SW-1:0] hw_req,
  output logic                      irq_o,
  output logic [VEC_W-1:0]          irq_vec,
  input  logic                      irq_ack,
  input  logic                      irq_eoi,
  output logic [PRIO_W-1:0]         cur_prio,
  output logic                      stack_err
);
  localparam int unsigned DEPTH_W = $clog2(STACK_DEPTH + 1);

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SW-1:0]         sw_pend;
  logic [NUM_SRC-1:0]        pend;
  logic                      cur_we;
  logic [PRIO_W-1:0]         cur_wval, cur_next, cur_q;
  logic [DEPTH_W-1:0]        depth_q;
  logic [VEC_W-1:0]          win_id;
  logic [PRIO_W-1:0]         win_prio, wprio_q;
  logic                      irq_q, ack_take, eoi_req, raise;
  logic [VEC_W-1:0]          vec_q;

  pic_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prio_flat(prio_flat),
    .sw_pend(sw_pend), .cur_we(cur_we), .cur_wval(cur_wval),
    .cur_prio(cur_q), .stk_depth(depth_q), .stk_err(stack_err)
  );

  assign pend = {hw_req, sw_pend};

  pic_arbiter #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_arb (
    .pend(pend), .prio_flat(prio_flat), .win_id(win_id), .win_prio(win_prio)
  );

  assign ack_take = irq_ack && irq_q;
  assign eoi_req  = irq_eoi && !irq_ack;

  pic_nest_stack #(
    .DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W)
  ) u_nest (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .eoi_req(eoi_req),
    .ack_prio(wprio_q), .cur_we(cur_we), .cur_wval(cur_wval),
    .cur_q(cur_q), .cur_next(cur_next), .depth_q(depth_q), .err_q(stack_err)
  );

  // compare against the priority that takes effect at this edge
  assign raise = win_prio > cur_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      wprio_q <= '0;
    end else begin
      irq_q   <= raise;
      vec_q   <= raise ? win_id : '0;
      wprio_q <= win_prio;
    end
  end

  assign irq_o    = irq_q;
  assign irq_vec  = vec_q;
  assign cur_prio = cur_q;

  a_r3_strict_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> wprio_q > cur_q);
  a_r2_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> wprio_q != '0);
  a_r3_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> vec_q < VEC_W'(NUM_SRC));
  a_r5_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> cur_q == $past(wprio_q));
  a_r11_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !irq_q && !cfg_we |=> cur_q == $past(cur_q) && depth_q == $past(depth_q));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int NSRC  = 155;
  localparam int NSW   = 8;
  localparam int NHW   = NSRC - NSW;
  localparam int DEPTH = 16;
  localparam int A_SWP  = 256;
  localparam int A_CUR  = 257;
  localparam int A_STAT = 258;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [8:0]     cfg_addr = '0;
  logic [15:0]    cfg_wdata = '0;
  logic [15:0]    cfg_rdata;
  logic [NHW-1:0] hw_req = '0;
  logic           irq_o;
  logic [8:0]     irq_vec;
  logic           irq_ack = 1'b0;
  logic           irq_eoi = 1'b0;
  logic [3:0]     cur_prio;
  logic           stack_err;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
    .irq_o(irq_o), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_eoi(irq_eoi),
    .cur_prio(cur_prio), .stack_err(stack_err)
  );

  int       checks = 0;
  int       fails  = 0;
  int       m_prio [NSRC];
  logic [NSW-1:0] m_sw;
  int       m_cur;
  int       m_stk [DEPTH];
  int       m_dep;
  int       m_err;

  function automatic void winner(output int id, output int p);
    id = 0; p = 0;
    for (int i = 0; i < NSRC; i++) begin
      logic pd;
      pd = (i < NSW) ? m_sw[i] : hw_req[i-NSW];
      if (pd && m_prio[i] > p) begin id = i; p = m_prio[i]; end
    end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag);
    int w, p, e;
    winner(w, p);
    e = (p > m_cur) ? 1 : 0;
    check({tag, " irq_o"}, int'(irq_o), e);
    check({tag, " irq_vec"}, int'(irq_vec), e ? w : 0);
    check({tag, " cur_prio"}, int'(cur_prio), m_cur);
    check({tag, " stack_err"}, int'(stack_err), m_err);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    cfg_addr = a[8:0];
    #1;
    check({tag, " rdata"}, int'(cfg_rdata), exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; irq_ack = 1'b0; irq_eoi = 1'b0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
    m_sw = '0; m_cur = 0; m_dep = 0; m_err = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hw_req = '0;
    step(); step();
    rst_n = 1'b1;
    model_reset();
    step();
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a[8:0]; cfg_wdata = d;
    if (a < NSRC) m_prio[a] = int'(d[3:0]);
    else if (a == A_SWP) m_sw = (m_sw | d[7:0]) & ~d[15:8];
    else if (a == A_CUR) m_cur = int'(d[3:0]);
    step(); step();
  endtask

  task automatic hw_set(input logic [NHW-1:0] v);
    hw_req = v;
    step(); step();
  endtask

  task automatic ack_op(input bit with_eoi);
    int w, p;
    winner(w, p);
    irq_ack = 1'b1; irq_eoi = with_eoi;
    if (p > m_cur) begin
      if (m_dep < DEPTH) begin m_stk[m_dep] = m_cur; m_dep++; end
      else m_err = 1;
      m_cur = p;
    end
    step(); step();
  endtask

  task automatic eoi_op();
    irq_eoi = 1'b1;
    if (m_dep > 0) begin m_dep--; m_cur = m_stk[m_dep]; end
    else m_err = 1;
    step(); step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NHW-1:0] hv;
    void'($urandom(32'd4471));
    model_reset();
    @(negedge clk);
    do_reset();

    // reset state
    check_state("R3 reset");
    rd_chk("R9 reset stat", A_STAT, 0);

    // R2 priority write and read back
    wr(20, 16'h0005);
    rd_chk("R2 prio readback", 20, 5);
    // R2 priority 0 never interrupts, R1 hardware line of source 30
    hv = '0; hv[30-NSW] = 1'b1;
    hw_set(hv);
    check_state("R2 zero prio silent");
    // R1/R3 source 20 pending at priority 5
    hv[20-NSW] = 1'b1;
    hw_set(hv);
    check_state("R1 hw source raises");
    check("R3 vector 20", int'(irq_vec), 20);
    // R4 ties: source 40 equal priority stays behind 20, source 12 wins
    wr(40, 16'h0005); hv[40-NSW] = 1'b1; hw_set(hv);
    check("R4 lower id kept", int'(irq_vec), 20);
    wr(12, 16'h0005); hv[12-NSW] = 1'b1; hw_set(hv);
    check("R4 lowest id wins", int'(irq_vec), 12);
    // R5 acknowledge raises current priority, equal pending cannot preempt
    ack_op(1'b0);
    check_state("R5 after ack");
    rd_chk("R9 depth one", A_STAT, 2);
    // R3 strictly higher preempts
    wr(50, 16'h0006); hv[50-NSW] = 1'b1; hw_set(hv);
    check_state("R3 preempt");
    ack_op(1'b0);
    check("R5 cur raised to 6", int'(cur_prio), 6);
    // R6 pops
    hv[50-NSW] = 1'b0; hw_set(hv);
    eoi_op();
    check("R6 first pop", int'(cur_prio), 5);
    eoi_op();
    check_state("R6 second pop");
    // R7 underflow
    eoi_op();
    check_state("R7 underflow");
    check("R7 err flag", int'(stack_err), 1);
    // R11 ack with irq low ignored
    hw_set('0);
    ack_op(1'b0);
    check_state("R11 ack ignored");
    rd_chk("R11 depth stays", A_STAT, 1);
    // R11 ack and eoi together: eoi dropped
    hv = '0; hv[20-NSW] = 1'b1; hw_set(hv);
    ack_op(1'b1);
    check_state("R11 ack wins over eoi");
    rd_chk("R11 depth one", A_STAT, 3);
    eoi_op();
    hw_set('0);

    // R8 software sources
    wr(3, 16'h0009);
    wr(A_SWP, 16'h0008);
    check_state("R8 sw set");
    check("R8 sw vector", int'(irq_vec), 3);
    ack_op(1'b0);
    rd_chk("R8 sw held after ack", A_SWP, 8);
    wr(A_SWP, 16'h0800);
    rd_chk("R8 sw cleared", A_SWP, 0);
    wr(A_SWP, 16'h0404);
    rd_chk("R8 clear beats set", A_SWP, 0);
    eoi_op();
    // R9 current priority write masks
    wr(A_SWP, 16'h0008);
    wr(A_CUR, 16'h000F);
    check_state("R9 cur write masks");
    rd_chk("R9 cur readback", A_CUR, 15);
    wr(A_CUR, 16'h0000);
    check_state("R9 cur lowered");

    // R7 overflow
    do_reset();
    wr(0, 16'h0001);
    wr(A_SWP, 16'h0001);
    for (int n = 0; n < DEPTH + 1; n++) begin
      ack_op(1'b0);
      wr(A_CUR, 16'h0000);
    end
    check_state("R7 overflow");
    rd_chk("R7 overflow stat", A_STAT, 33);

    // R10 latency of a hardware line: one edge
    do_reset();
    wr(60, 16'h0007);
    hw_req[60-NSW] = 1'b1;
    #1 check("R10 hw before edge", int'(irq_o), 0);
    @(posedge clk); #1;
    check("R10 hw one edge irq", int'(irq_o), 1);
    check("R10 hw one edge vec", int'(irq_vec), 60);
    @(negedge clk);
    // R10 latency of a priority write: two edges
    hw_req = '0; hw_req[70-NSW] = 1'b1;
    step();
    cfg_we = 1'b1; cfg_addr = 9'd70; cfg_wdata = 16'h0003;
    m_prio[70] = 3;
    @(posedge clk); #1;
    check("R10 write first edge", int'(irq_o), 0);
    @(negedge clk); cfg_we = 1'b0;
    @(posedge clk); #1;
    check("R10 write second edge", int'(irq_vec), 70);
    @(negedge clk);
    check_state("R10 settled");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 8);
      case (k)
        0, 1: begin
          for (int b = 0; b < NHW; b++) hv[b] = ($urandom % 12) == 0;
          hw_set(hv);
        end
        2: wr(int'($urandom % NSRC), 16'($urandom % 16));
        3: wr(A_SWP, 16'($urandom));
        4, 5: ack_op(($urandom % 6) == 0);
        6: eoi_op();
        default: wr(A_CUR, 16'($urandom % 16));
      endcase
      check_state("R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule